// File: doc/BRIEF.md
# Lockable Watchdog and Interval Timer

This block is a free-running timer run by a single 8-bit control register. Three bits of the register matter. The run flag starts the count. The two role bits decide what a counter overflow does: it can raise a one-cycle maskable interrupt as a periodic tick, raise a one-cycle non-maskable interrupt, or raise a system reset request that stays asserted. The counter advances only on cycles where the count-enable input is high, so an outside prescaler sets the time base.

Software can only set these bits. Clearing them takes a hardware reset. A write to the control register counts only when the bus write just before it was the key value 0xA5 sent to a separate key address. An accepted write that sets the run flag also clears the counter, and software uses that write as the watchdog service. Each write can change the whole byte or a single bit.

Top module: `gtm_top`

## Requirements
- R1: After reset the control register reads 0x00, the counter is stopped, and all three event outputs are low.
- R2: Reading address 0 gives the control register, with the run flag at bit 7, role-high at bit 4 and role-low at bit 3. Every other bit reads 0. Any other address reads 0x00.
- R3: A write to address 0 is accepted only if the bus write just before it was 0xA5 to address 1. Any other bus write in between cancels the unlock, and a write that is not accepted changes nothing.
- R4: Software cannot clear the run flag or either role bit. Writing 0 to one of them leaves it at 1.
- R5: With `bus_bit_en` low, the write uses all of `bus_wdata`. With `bus_bit_en` high, only bit `bus_bit_sel` is written, and it takes the value of `bus_wdata[0]`.
- R6: While the run flag is 0 the counter holds and no event is produced. An accepted write with the run bit at 1 clears the counter to 0 and starts or restarts counting, whether or not the timer was already running.
- R7: While running, the counter advances only on cycles with `cnt_en` high. It overflows on the enabled cycle where it equals LIMIT, wraps to 0 and keeps running, so overflows come every LIMIT+1 enabled cycles.
- R8: With role bits (high, low) = 00, each overflow drives `irq_tick` high for exactly one cycle, the cycle after the overflow edge.
- R9: With role bits 01, each overflow drives `nmi_pulse` high for one cycle, with the same timing as R8.
- R10: With role bits 10 or 11, an overflow sets `rst_req`, which stays high until hardware reset.
- R11: When an accepted run write falls on the same cycle as a pending overflow, the counter is cleared and no event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Register address: 0 is the control register, 1 is the key register |
| bus_wdata | input | 8 | Write data |
| bus_bit_en | input | 1 | Selects a single-bit write |
| bus_bit_sel | input | 3 | Bit index for a single-bit write |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cnt_en | input | 1 | Count enable from the prescaler |
| irq_tick | output | 1 | Maskable interrupt pulse (interval role) |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse (watchdog role 1) |
| rst_req | output | 1 | Held system reset request (watchdog role 2) |

## Verification
The assertions assume that the bus makes at most one write per cycle. They also assume that `bus_addr` and the write data stay steady across the clock edge, and that `rst_n` is held low long enough to reach every register. The bench changes all inputs on the falling edge only, and issues writes as single-cycle strobes. The written values are chosen so that unlock sequences are sometimes interrupted and sometimes completed. Service writes are placed at many different offsets from the overflow point, so at least one of them lands on the overflow cycle itself.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

  localparam int          DATA_W   = 8;
  localparam int          RUN_POS  = 7;
  localparam int          HI_POS   = 4;
  localparam int          LO_POS   = 3;
  localparam logic [7:0]  LIVE_MASK = 8'h98;
  localparam logic [7:0]  KEY_VAL  = 8'hA5;

  typedef enum logic [1:0] {
    ROLE_TICK  = 2'd0,
    ROLE_NMI   = 2'd1,
    ROLE_RESET = 2'd2
  } gtm_role_e;

  // Bits a write is trying to set: whole byte, or one bit from data[0].
  function automatic logic [7:0] gtm_set_bits(input logic bit_mode,
                                               input logic [2:0] sel,
                                               input logic [7:0] data);
    logic [7:0] m;
    if (bit_mode) begin
      m = 8'h00;
      m[sel] = data[0];
    end else begin
      m = data;
    end
    return m & LIVE_MASK;
  endfunction

  function automatic gtm_role_e gtm_role(input logic hi, input logic lo);
    if (hi)      return ROLE_RESET;
    else if (lo) return ROLE_NMI;
    else         return ROLE_TICK;
  endfunction

  function automatic logic [7:0] gtm_view(input logic run, input logic hi,
                                          input logic lo);
    logic [7:0] v;
    v = 8'h00;
    v[RUN_POS] = run;
    v[HI_POS]  = hi;
    v[LO_POS]  = lo;
    return v;
  endfunction

endpackage

// File: rtl/gtm_regs.sv
module gtm_regs
  import gtm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_bit_en,
  input  logic [2:0]        bus_bit_sel,
  output logic [7:0]        bus_rdata,
  output logic              run_q,
  output logic              hi_q,
  output logic              lo_q,
  output logic              kick
);

  logic       unlock_q;
  logic       ctrl_hit;
  logic       key_hit;
  logic       accept;
  logic [7:0] set_bits;

  assign ctrl_hit = bus_we && (bus_addr == CTRL_ADDR);
  assign key_hit  = bus_we && (bus_addr == KEY_ADDR) && (bus_wdata == KEY_VAL);
  assign accept   = ctrl_hit && unlock_q;
  assign set_bits = gtm_set_bits(bus_bit_en, bus_bit_sel, bus_wdata);
  assign kick     = accept && set_bits[RUN_POS];

  // Key arms the unlock, any other write drops it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlock_q <= 1'b0;
    else if (bus_we) unlock_q <= key_hit;
  end

  // Set-only flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (accept) begin
      run_q <= run_q | set_bits[RUN_POS];
      hi_q  <= hi_q  | set_bits[HI_POS];
      lo_q  <= lo_q  | set_bits[LO_POS];
    end
  end

  assign bus_rdata = (bus_addr == CTRL_ADDR) ? gtm_view(run_q, hi_q, lo_q) : 8'h00;

  a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  a_r4_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |=> hi_q);
  a_r4_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q |=> lo_q);
  a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !unlock_q) |=> ($stable(run_q) && $stable(hi_q) && $stable(lo_q)));
  a_r3_unlock_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !key_hit) |=> !unlock_q);

endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int               CNT_W = 16,
  parameter logic [CNT_W-1:0] LIMIT = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cnt_en,
  input  logic kick,
  output logic ovf
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;
  logic             step;

  assign at_limit = (cnt_q == LIMIT);
  assign step     = run && cnt_en;
  assign ovf      = step && at_limit && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (kick)     cnt_q <= '0;
    else if (step)     cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

  a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  a_r7_gated_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en && !kick) |=> $stable(cnt_q));
  a_r11_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));

endmodule

// File: rtl/gtm_event.sv
module gtm_event
  import gtm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovf,
  input  gtm_role_e role,
  output logic      irq_tick,
  output logic      nmi_pulse,
  output logic      rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tick  <= 1'b0;
      nmi_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      irq_tick  <= ovf && (role == ROLE_TICK);
      nmi_pulse <= ovf && (role == ROLE_NMI);
      if (ovf && (role == ROLE_RESET)) rst_req <= 1'b1;
    end
  end

  a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_tick, nmi_pulse}));
  a_r8_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tick && !ovf) |=> !irq_tick);
  a_r9_nmi_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pulse && !ovf) |=> !nmi_pulse);
  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

endmodule

// File: rtl/gtm_top.sv
module gtm_top
  import gtm_pkg::*;
#(
  parameter int               ADDR_W = 4,
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] LIMIT  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_bit_en,
  input  logic [2:0]        bus_bit_sel,
  output logic [7:0]        bus_rdata,
  input  logic              cnt_en,
  output logic              irq_tick,
  output logic              nmi_pulse,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] KEY_ADDR  = 1;

  logic      run_q, hi_q, lo_q;
  logic      kick;
  logic      ovf;
  gtm_role_e role;

  assign role = gtm_role(hi_q, lo_q);

  gtm_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .KEY_ADDR (KEY_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_bit_en (bus_bit_en),
    .bus_bit_sel(bus_bit_sel),
    .bus_rdata  (bus_rdata),
    .run_q      (run_q),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .kick       (kick)
  );

  gtm_counter #(
    .CNT_W(CNT_W),
    .LIMIT(LIMIT)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .cnt_en(cnt_en),
    .kick  (kick),
    .ovf   (ovf)
  );

  gtm_event u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf      (ovf),
    .role     (role),
    .irq_tick (irq_tick),
    .nmi_pulse(nmi_pulse),
    .rst_req  (rst_req)
  );

  a_r6_no_event_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !(irq_tick || nmi_pulse));
  a_r11_kick_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !(irq_tick || nmi_pulse));

endmodule

// File: tb/gtm_top_tb.sv
module gtm_top_tb;

  localparam int LIM = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_bit_en = 1'b0;
  logic [2:0] bus_bit_sel = '0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0;
  logic       irq_tick, nmi_pulse, rst_req;

  int    n_checks = 0;
  int    n_fails = 0;
  int    cycles = 0;
  string cur = "R1";

  always #4 clk = ~clk;

  gtm_top #(.ADDR_W(4), .CNT_W(16), .LIMIT(16'(LIM))) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bit_en(bus_bit_en), .bus_bit_sel(bus_bit_sel),
    .bus_rdata(bus_rdata), .cnt_en(cnt_en), .irq_tick(irq_tick),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  // Behavioural reference model.
  bit m_run, m_hi, m_lo, m_unl, m_irq, m_nmi, m_rst;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin : model
    bit [7:0] want;
    bit acc, kick, ovf;
    if (!rst_n) begin
      m_run = 0; m_hi = 0; m_lo = 0; m_unl = 0;
      m_irq = 0; m_nmi = 0; m_rst = 0; m_cnt = 0;
    end else begin
      want = 8'h00;
      if (bus_bit_en) want[bus_bit_sel] = bus_wdata[0];
      else            want = bus_wdata;
      acc  = bus_we && bus_addr == 0 && m_unl;
      kick = acc && want[7];
      ovf  = m_run && cnt_en && m_cnt == LIM && !kick;
      m_irq = ovf && !m_hi && !m_lo;
      m_nmi = ovf && !m_hi && m_lo;
      if (ovf && m_hi) m_rst = 1;
      if (kick) m_cnt = 0;
      else if (m_run && cnt_en) m_cnt = (m_cnt == LIM) ? 0 : m_cnt + 1;
      if (acc) begin
        m_run = m_run | want[7];
        m_hi  = m_hi  | want[4];
        m_lo  = m_lo  | want[3];
      end
      if (bus_we) m_unl = (bus_addr == 1 && bus_wdata == 8'hA5);
    end
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("bus_rdata", bus_rdata,
          (bus_addr == 0) ? {m_run, 2'b00, m_hi, m_lo, 3'b000} : 0);
      chk("irq_tick", irq_tick, m_irq);
      chk("nmi_pulse", nmi_pulse, m_nmi);
      chk("rst_req", rst_req, m_rst);
    end
    cycles++;
    if (cycles > 100000) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic idle(int n, bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle) cnt_en = (i % 3) != 1;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, bit bm, logic [2:0] sel);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; bus_bit_en = bm; bus_bit_sel = sel;
    @(negedge clk);
    bus_we = 0; bus_addr = 0; bus_bit_en = 0; bus_wdata = 0;
  endtask

  task automatic unlock();
    wr(4'd1, 8'hA5, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle(3, 0);
    rst_n = 1;
  endtask

  initial begin
    idle(3, 0);
    rst_n = 1;
    cur = "R1"; idle(3, 0);
    // R1 reset state checked directly as well
    chk("reset rdata", bus_rdata, 0);
    cur = "R3";
    wr(0, 8'h98, 0, 0); idle(2, 0);
    unlock(); wr(2, 8'h00, 0, 0); wr(0, 8'h98, 0, 0); idle(2, 0);
    wr(1, 8'h5A, 0, 0); wr(0, 8'h98, 0, 0); idle(2, 0);
    cur = "R6"; cnt_en = 1; idle(12, 0);
    unlock(); wr(0, 8'h80, 0, 0);
    cur = "R8"; idle(20, 0);
    cur = "R7"; idle(30, 1); cnt_en = 1;
    cur = "R4"; unlock(); wr(0, 8'h00, 0, 0); idle(10, 0);
    cur = "R11";
    for (int k = 0; k < 9; k++) begin
      unlock(); wr(0, 8'h80, 0, 0); idle(k, 0);
    end
    idle(10, 0);
    cur = "R5";
    unlock(); wr(0, 8'h01, 1, 3'd5); idle(3, 0);
    unlock(); wr(0, 8'h01, 1, 3'd3);
    cur = "R9"; idle(20, 0);
    cur = "R2"; unlock(); wr(0, 8'hFF, 0, 0); wr(1, 8'h00, 0, 0);
    cur = "R10"; idle(20, 0);
    do_reset();
    cur = "R1"; idle(3, 0);
    cur = "R10"; unlock(); wr(0, 8'h90, 0, 0); idle(20, 0);
    cur = "R5"; unlock(); wr(0, 8'h00, 1, 3'd7); idle(4, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule